// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This unit forms the second source operand of a data-processing instruction and the carry bit produced by the shifter along the way. It is purely combinational. It receives the full 32-bit instruction word, the value read from the shifted source register, the low byte of the shift-amount register and the processor's present carry flag. The execute stage feeds `operand` to its ALU and uses `shifter_carry` as the new C flag for logical operations.

Three operand forms are decoded from the instruction word. The first, `FORM_IMM`, is an 8-bit constant rotated by an even amount. The second, `FORM_SHIMM`, is the register value shifted by a 5-bit constant. The third, `FORM_SHREG`, is the register value shifted by an amount taken from the register byte.

Zero amounts have special meanings, and so do amounts of 32 and above. Internally these cases are normalised into a shift kind and an amount. The kinds are `SK_PASS`, `SK_LSL`, `SK_LSR`, `SK_ASR`, `SK_ROR` and `SK_RRX`, and the amount runs from 0 to 33. A single barrel stage then evaluates every form from that pair. There are no states and no transitions: each output depends only on the inputs present in the same cycle.

Top module: `shop_operand_unit`

## Requirements
- R1: When instruction bit 25 is 1 (the immediate form), `operand` is the zero-extended `insn[7:0]` rotated right by twice `insn[11:8]`, and `rm_val` has no effect.
- R2: In the immediate form, `shifter_carry` equals `carry_in` when `insn[11:8]` is 0 and equals `operand[31]` otherwise.
- R3: With bit 25 at 0, `insn[6:5]` selects the shift type (00 LSL, 01 LSR, 10 ASR, 11 ROR), `insn[4]`=1 selects a register amount, and `insn[11:7]` is the constant amount. For a constant amount n in 1..31, the result is `rm_val` shifted by n and the carry is the last bit shifted out: bit 32-n for LSL and bit n-1 for the others.
- R4: An LSL by constant 0 returns `rm_val` unchanged with carry equal to `carry_in`.
- R5: An LSR by constant 0 acts as a 32-bit shift, giving 0 with carry equal to `rm_val[31]`.
- R6: An ASR by constant 0 acts as a 32-bit shift, giving every bit equal to `rm_val[31]` with carry equal to `rm_val[31]`.
- R7: A ROR by constant 0 is a rotate-through-carry by one. The result is `{carry_in, rm_val[31:1]}` and the carry is `rm_val[0]`.
- R8: A register amount of 0 returns `rm_val` unchanged with carry equal to `carry_in`, for every shift type.
- R9: A register LSL by exactly 32 gives 0 with carry `rm_val[0]`. A register LSR by exactly 32 gives 0 with carry `rm_val[31]`.
- R10: A register LSL or LSR by more than 32 gives 0 with carry 0.
- R11: A register ASR by 32 or more gives all bits equal to `rm_val[31]`, with carry `rm_val[31]`.
- R12: A register ROR uses the amount modulo 32. A nonzero multiple of 32 returns `rm_val` with carry `rm_val[31]`, and any other amount rotates by the remainder, with the carry equal to the result's bit 31.
- R13: Only `rs_low` (bits 7:0 of the amount register) sets a register amount, and both outputs settle in the same cycle as their inputs, with no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word holding the form, type and amount fields |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_low | input | 8 | Low byte of the register that holds the shift amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted or rotated second operand |
| shifter_carry | output | 1 | Carry-out of the shifter |

## Verification
Every result of this unit is due zero cycles after its stimulus, because no register lies between the inputs and `operand` or `shifter_carry`. The bench applies each input set just after a rising clock edge and reads both outputs at the following falling edge, half a period later. That gives the combinational path time to settle and keeps the sample clear of any edge. Each expected value is written from the requirement it checks. The checker's immediate assertions look at the same outputs whenever an input changes.

// File: rtl/shop_pkg.sv
package shop_pkg;

    localparam int DATA_W   = 32;
    localparam int IMM_W    = 8;
    localparam int ROTF_W   = 4;
    localparam int RSAMT_W  = 8;
    localparam int SHAMT_W  = $clog2(DATA_W);
    localparam int AMT_W    = SHAMT_W + 1;

    // Field positions inside the instruction word
    localparam int BIT_IMM_FORM = 25;
    localparam int BIT_REG_AMT  = 4;
    localparam int TYPE_LO      = 5;
    localparam int SHAMT_LO     = 7;
    localparam int ROTF_LO      = 8;

    typedef enum logic [1:0] {
        ST_LSL = 2'b00,
        ST_LSR = 2'b01,
        ST_ASR = 2'b10,
        ST_ROR = 2'b11
    } shift_type_e;

    typedef enum logic [1:0] {
        FORM_IMM   = 2'b00,
        FORM_SHIMM = 2'b01,
        FORM_SHREG = 2'b10
    } operand_form_e;

    typedef enum logic [2:0] {
        SK_PASS = 3'd0,
        SK_LSL  = 3'd1,
        SK_LSR  = 3'd2,
        SK_ASR  = 3'd3,
        SK_ROR  = 3'd4,
        SK_RRX  = 3'd5
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e        kind;
        logic [AMT_W-1:0]   amount;
    } shift_ctrl_t;

endpackage

// File: rtl/shop_amount.sv
// Normalises a register-held shift amount into a kind and an amount (0..W+1).
module shop_amount
    import shop_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int RS_W   = RSAMT_W,
    parameter int A_W    = AMT_W,
    parameter int SH_W   = SHAMT_W
) (
    input  shift_type_e       stype,
    input  logic [RS_W-1:0]   rs_amt,
    output shift_ctrl_t       ctrl
);

    localparam logic [RS_W-1:0] FULL_RS   = RS_W'(W);
    localparam logic [A_W-1:0]  FULL_AMT  = A_W'(W);
    localparam logic [A_W-1:0]  BEYOND    = A_W'(W + 1);

    logic [SH_W-1:0] rot_low;
    assign rot_low = rs_amt[SH_W-1:0];

    always_comb begin
        ctrl.kind   = SK_PASS;
        ctrl.amount = '0;
        if (rs_amt != '0) begin
            unique case (stype)
                ST_LSL: begin
                    ctrl.kind   = SK_LSL;
                    ctrl.amount = (rs_amt > FULL_RS) ? BEYOND : rs_amt[A_W-1:0];
                end
                ST_LSR: begin
                    ctrl.kind   = SK_LSR;
                    ctrl.amount = (rs_amt > FULL_RS) ? BEYOND : rs_amt[A_W-1:0];
                end
                ST_ASR: begin
                    ctrl.kind   = SK_ASR;
                    ctrl.amount = (rs_amt >= FULL_RS) ? FULL_AMT : rs_amt[A_W-1:0];
                end
                ST_ROR: begin
                    ctrl.kind   = SK_ROR;
                    ctrl.amount = (rot_low == '0) ? FULL_AMT : {1'b0, rot_low};
                end
                default: begin
                    ctrl.kind   = SK_PASS;
                    ctrl.amount = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/shop_decode.sv
// Chooses the operand form and source, and maps constant amounts to a kind.
module shop_decode
    import shop_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int IW    = IMM_W,
    parameter int RF_W  = ROTF_W,
    parameter int SH_W  = SHAMT_W,
    parameter int A_W   = AMT_W
) (
    input  logic              imm_form,
    input  logic              reg_amt,
    input  shift_type_e       stype,
    input  logic [SH_W-1:0]   shamt,
    input  logic [RF_W-1:0]   rotf,
    input  logic [IW-1:0]     imm8,
    input  logic [W-1:0]      rm_val,
    input  shift_ctrl_t       reg_ctrl,
    output operand_form_e     form,
    output logic [W-1:0]      src,
    output shift_ctrl_t       ctrl
);

    localparam logic [A_W-1:0] FULL_AMT = A_W'(W);

    always_comb begin
        if (imm_form)     form = FORM_IMM;
        else if (reg_amt) form = FORM_SHREG;
        else              form = FORM_SHIMM;
    end

    always_comb begin
        src         = rm_val;
        ctrl.kind   = SK_PASS;
        ctrl.amount = '0;
        unique case (form)
            FORM_IMM: begin
                src         = {{(W-IW){1'b0}}, imm8};
                ctrl.kind   = (rotf == '0) ? SK_PASS : SK_ROR;
                ctrl.amount = A_W'({rotf, 1'b0});
            end
            FORM_SHREG: begin
                ctrl = reg_ctrl;
            end
            FORM_SHIMM: begin
                unique case (stype)
                    ST_LSL: begin
                        ctrl.kind   = (shamt == '0) ? SK_PASS : SK_LSL;
                        ctrl.amount = {1'b0, shamt};
                    end
                    ST_LSR: begin
                        ctrl.kind   = SK_LSR;
                        ctrl.amount = (shamt == '0) ? FULL_AMT : {1'b0, shamt};
                    end
                    ST_ASR: begin
                        ctrl.kind   = SK_ASR;
                        ctrl.amount = (shamt == '0) ? FULL_AMT : {1'b0, shamt};
                    end
                    ST_ROR: begin
                        ctrl.kind   = (shamt == '0) ? SK_RRX : SK_ROR;
                        ctrl.amount = {1'b0, shamt};
                    end
                    default: begin
                        ctrl.kind   = SK_PASS;
                        ctrl.amount = '0;
                    end
                endcase
            end
            default: begin
                src         = rm_val;
                ctrl.kind   = SK_PASS;
                ctrl.amount = '0;
            end
        endcase
    end

endmodule

// File: rtl/shop_barrel.sv
// One barrel stage evaluating every normalised shift kind with its carry-out.
module shop_barrel
    import shop_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int A_W = AMT_W
) (
    input  shift_ctrl_t       ctrl,
    input  logic [W-1:0]      src,
    input  logic              carry_in,
    output logic [W-1:0]      result,
    output logic              carry_out
);

    localparam logic [A_W-1:0] FULL_AMT = A_W'(W);

    logic [W:0]          lsl_ext;
    logic [W:0]          lsr_ext;
    logic signed [W:0]   asr_ext;
    logic [W-1:0]        ror_val;

    // One extra bit beyond the word catches the last bit shifted out
    assign lsl_ext = {1'b0, src} << ctrl.amount;
    assign lsr_ext = {src, 1'b0} >> ctrl.amount;
    assign asr_ext = $signed({src, 1'b0}) >>> ctrl.amount;
    assign ror_val = (src >> ctrl.amount) | (src << (FULL_AMT - ctrl.amount));

    always_comb begin
        result    = src;
        carry_out = carry_in;
        unique case (ctrl.kind)
            SK_PASS: begin
                result    = src;
                carry_out = carry_in;
            end
            SK_LSL: begin
                result    = lsl_ext[W-1:0];
                carry_out = lsl_ext[W];
            end
            SK_LSR: begin
                result    = lsr_ext[W:1];
                carry_out = lsr_ext[0];
            end
            SK_ASR: begin
                result    = asr_ext[W:1];
                carry_out = asr_ext[0];
            end
            SK_ROR: begin
                result    = ror_val;
                carry_out = ror_val[W-1];
            end
            SK_RRX: begin
                result    = {carry_in, src[W-1:1]};
                carry_out = src[0];
            end
            default: begin
                result    = src;
                carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/shop_operand_unit.sv
// Top: second-operand generator with shifter carry-out.
module shop_operand_unit
    import shop_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [31:0]   insn,
    input  logic [W-1:0]  rm_val,
    input  logic [7:0]    rs_low,
    input  logic          carry_in,
    output logic [W-1:0]  operand,
    output logic          shifter_carry
);

    shift_type_e    stype;
    shift_ctrl_t    reg_ctrl;
    shift_ctrl_t    ctrl;
    operand_form_e  form;
    logic [W-1:0]   src;

    assign stype = shift_type_e'(insn[TYPE_LO +: 2]);

    shop_amount #(
        .W    (W),
        .RS_W (RSAMT_W),
        .A_W  (AMT_W),
        .SH_W (SHAMT_W)
    ) u_amount (
        .stype  (stype),
        .rs_amt (rs_low),
        .ctrl   (reg_ctrl)
    );

    shop_decode #(
        .W    (W),
        .IW   (IMM_W),
        .RF_W (ROTF_W),
        .SH_W (SHAMT_W),
        .A_W  (AMT_W)
    ) u_decode (
        .imm_form (insn[BIT_IMM_FORM]),
        .reg_amt  (insn[BIT_REG_AMT]),
        .stype    (stype),
        .shamt    (insn[SHAMT_LO +: SHAMT_W]),
        .rotf     (insn[ROTF_LO +: ROTF_W]),
        .imm8     (insn[IMM_W-1:0]),
        .rm_val   (rm_val),
        .reg_ctrl (reg_ctrl),
        .form     (form),
        .src      (src),
        .ctrl     (ctrl)
    );

    shop_barrel #(
        .W   (W),
        .A_W (AMT_W)
    ) u_barrel (
        .ctrl      (ctrl),
        .src       (src),
        .carry_in  (carry_in),
        .result    (operand),
        .carry_out (shifter_carry)
    );

endmodule

// File: rtl/shop_operand_unit_chk.sv
// Port-level checks on the operand unit, attached by bind.
module shop_operand_unit_chk (
    input logic [31:0] insn,
    input logic [31:0] rm_val,
    input logic [7:0]  rs_low,
    input logic        carry_in,
    input logic [31:0] operand,
    input logic        shifter_carry
);

    logic shreg;
    assign shreg = !insn[25] && insn[4];

    always_comb begin
        if (insn[25] && insn[11:8] == 4'd0) begin
            assert_imm_norot_R2: assert (operand == {24'd0, insn[7:0]} && shifter_carry == carry_in)
                else $error("unrotated immediate mismatch");
        end
        if (insn[25] && insn[11:8] != 4'd0) begin
            assert_imm_carry_R2: assert (shifter_carry == operand[31])
                else $error("rotated immediate carry mismatch");
        end
        if (!insn[25] && !insn[4] && insn[6:5] == 2'b01 && insn[11:7] == 5'd0) begin
            assert_lsr_full_R5: assert (operand == 32'd0 && shifter_carry == rm_val[31])
                else $error("lsr by 32 mismatch");
        end
        if (!insn[25] && !insn[4] && insn[6:5] == 2'b10 && insn[11:7] == 5'd0) begin
            assert_asr_full_R6: assert (operand == {32{rm_val[31]}} && shifter_carry == rm_val[31])
                else $error("asr by 32 mismatch");
        end
        if (!insn[25] && !insn[4] && insn[6:5] == 2'b11 && insn[11:7] == 5'd0) begin
            assert_rrx_R7: assert (operand[31] == carry_in && shifter_carry == rm_val[0])
                else $error("rrx mismatch");
        end
        if (shreg && rs_low == 8'd0) begin
            assert_reg_zero_R8: assert (operand == rm_val && shifter_carry == carry_in)
                else $error("zero register amount mismatch");
        end
        if (shreg && !insn[6] && rs_low > 8'd32) begin
            assert_beyond_R10: assert (operand == 32'd0 && !shifter_carry)
                else $error("logical shift beyond width mismatch");
        end
        if (shreg && insn[6:5] == 2'b10 && rs_low >= 8'd32) begin
            assert_asr_sat_R11: assert (operand == {32{rm_val[31]}} && shifter_carry == rm_val[31])
                else $error("register asr saturation mismatch");
        end
        if (shreg && insn[6:5] == 2'b11 && rs_low != 8'd0) begin
            assert_ror_carry_R12: assert (shifter_carry == operand[31])
                else $error("register ror carry mismatch");
        end
    end

endmodule

bind shop_operand_unit shop_operand_unit_chk u_chk (
    .insn          (insn),
    .rm_val        (rm_val),
    .rs_low        (rs_low),
    .carry_in      (carry_in),
    .operand       (operand),
    .shifter_carry (shifter_carry)
);

// File: tb/shop_operand_unit_test.sv
`timescale 1ns/1ps
module shop_operand_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] rm_val = '0;
    logic [7:0]  rs_low = '0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        shifter_carry;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shop_operand_unit uut (
        .insn          (insn),
        .rm_val        (rm_val),
        .rs_low        (rs_low),
        .carry_in      (carry_in),
        .operand       (operand),
        .shifter_carry (shifter_carry)
    );

    function automatic logic [31:0] f_imm(input logic [3:0] rot, input logic [7:0] imm);
        return 32'h0200_0000 | (32'(rot) << 8) | 32'(imm);
    endfunction

    function automatic logic [31:0] f_shimm(input logic [1:0] typ, input logic [4:0] amt);
        return (32'(amt) << 7) | (32'(typ) << 5);
    endfunction

    function automatic logic [31:0] f_shreg(input logic [1:0] typ);
        return 32'h0000_0010 | (32'(typ) << 5);
    endfunction

    // Apply after a rising edge, sample at the following falling edge
    task automatic apply_check(input string req, input logic [31:0] i_w,
                               input logic [31:0] rm, input logic [7:0] rs,
                               input logic cin, input logic [31:0] exp_op,
                               input logic exp_c);
        @(posedge clk);
        #0.5;
        insn = i_w; rm_val = rm; rs_low = rs; carry_in = cin;
        @(negedge clk);
        checks++;
        if (operand !== exp_op || shifter_carry !== exp_c) begin
            failures++;
            $display("FAIL %s: actual op=%08h c=%0b expected op=%08h c=%0b",
                     req, operand, shifter_carry, exp_op, exp_c);
        end
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        apply_check("R4 idle", 32'd0, 32'd0, 8'd0, 1'b0, 32'd0, 1'b0);
    endtask

    task automatic t_immediate;
        apply_check("R1 norot", f_imm(4'd0, 8'hAB), 32'hDEAD_BEEF, 8'd0, 1'b1, 32'h0000_00AB, 1'b1);
        apply_check("R2 rot8", f_imm(4'd4, 8'hFF), 32'h0, 8'd0, 1'b0, 32'hFF00_0000, 1'b1);
        apply_check("R2 rot2", f_imm(4'd1, 8'h01), 32'hFFFF_FFFF, 8'd0, 1'b1, 32'h4000_0000, 1'b0);
    endtask

    task automatic t_const_shifts;
        apply_check("R3 lsl4", f_shimm(2'b00, 5'd4), 32'hF000_0001, 8'd0, 1'b0, 32'h0000_0010, 1'b1);
        apply_check("R3 lsr1", f_shimm(2'b01, 5'd1), 32'h0000_0003, 8'd0, 1'b0, 32'h0000_0001, 1'b1);
        apply_check("R3 asr4", f_shimm(2'b10, 5'd4), 32'h8000_0010, 8'd0, 1'b1, 32'hF800_0001, 1'b0);
        apply_check("R3 ror8", f_shimm(2'b11, 5'd8), 32'h1234_5678, 8'd0, 1'b1, 32'h7812_3456, 1'b0);
    endtask

    task automatic t_const_zero;
        apply_check("R4 lsl0", f_shimm(2'b00, 5'd0), 32'h0000_1234, 8'd0, 1'b1, 32'h0000_1234, 1'b1);
        apply_check("R5 lsr0", f_shimm(2'b01, 5'd0), 32'h8000_0000, 8'd0, 1'b0, 32'h0, 1'b1);
        apply_check("R6 asr0 neg", f_shimm(2'b10, 5'd0), 32'h8000_0000, 8'd0, 1'b0, 32'hFFFF_FFFF, 1'b1);
        apply_check("R6 asr0 pos", f_shimm(2'b10, 5'd0), 32'h7FFF_FFFF, 8'd0, 1'b1, 32'h0, 1'b0);
        apply_check("R7 rrx c1", f_shimm(2'b11, 5'd0), 32'h0000_0003, 8'd0, 1'b1, 32'h8000_0001, 1'b1);
        apply_check("R7 rrx c0", f_shimm(2'b11, 5'd0), 32'h0000_0002, 8'd0, 1'b0, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_reg_zero;
        for (int t = 0; t < 4; t++) begin
            apply_check("R8 reg0", f_shreg(t[1:0]), 32'h0000_0005, 8'd0, 1'b1, 32'h0000_0005, 1'b1);
        end
        apply_check("R8 reg0 c0", f_shreg(2'b11), 32'h8000_0001, 8'd0, 1'b0, 32'h8000_0001, 1'b0);
    endtask

    task automatic t_reg_edges;
        apply_check("R13 lsl5", f_shreg(2'b00), 32'h0800_0001, 8'd5, 1'b0, 32'h0000_0020, 1'b1);
        apply_check("R13 lsr31", f_shreg(2'b01), 32'hC000_0000, 8'd31, 1'b0, 32'h0000_0001, 1'b1);
        apply_check("R9 lsl32", f_shreg(2'b00), 32'h0000_0001, 8'd32, 1'b0, 32'h0, 1'b1);
        apply_check("R9 lsr32", f_shreg(2'b01), 32'h8000_0000, 8'd32, 1'b0, 32'h0, 1'b1);
        apply_check("R10 lsl33", f_shreg(2'b00), 32'hFFFF_FFFF, 8'd33, 1'b1, 32'h0, 1'b0);
        apply_check("R10 lsr200", f_shreg(2'b01), 32'hFFFF_FFFF, 8'd200, 1'b1, 32'h0, 1'b0);
        apply_check("R11 asr40", f_shreg(2'b10), 32'h8000_0000, 8'd40, 1'b0, 32'hFFFF_FFFF, 1'b1);
        apply_check("R11 asr32", f_shreg(2'b10), 32'h4000_0000, 8'd32, 1'b1, 32'h0, 1'b0);
        apply_check("R12 ror36", f_shreg(2'b11), 32'h0000_00F1, 8'd36, 1'b1, 32'h1000_000F, 1'b0);
        apply_check("R12 ror64", f_shreg(2'b11), 32'h8000_0001, 8'd64, 1'b0, 32'h8000_0001, 1'b1);
        apply_check("R12 ror32", f_shreg(2'b11), 32'h0000_0001, 8'd32, 1'b1, 32'h0000_0001, 1'b0);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_immediate();
        t_const_shifts();
        t_const_zero();
        t_reg_zero();
        t_reg_edges();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule